// File: doc/BRIEF.md
# Dual-Clock FIFO with Loadable Watermark Flags

This block is a 64-entry by 9-bit first-in first-out buffer. Its write side and its read side each run on their own clock, and the two clocks may be unrelated or may be the same net. Each side acts only when both of its two enable inputs are high. The write side stores a word on every write-clock edge where it is qualified. The read side moves the oldest word into a registered output on every read-clock edge where it is qualified. A separate output-enable input drives the read bus to high impedance when it is low.

Four status flags report the fill level. Empty and almost-empty are produced in the read clock domain. Full and almost-full are produced in the write clock domain. The two watermark thresholds are kept in a small offset store, and both start at 7 after reset. While the load input is high, each qualified write-clock cycle writes the next offset into that store in turn and puts no data into the buffer. The pointers cross between the clock domains as Gray code through two-flop synchronisers.

Top module: `dcfifo_pf`

## Requirements
- R1: Words leave the read port in the order they entered the write port, and the buffer holds up to 64 words of 9 bits.
- R2: A word is stored only on a write-clock edge where both write enables are high and the load input is low; with either enable low, nothing is stored.
- R3: A qualified write while full is high is dropped: the write pointer does not move and no word is lost or duplicated.
- R4: A read happens only on a read-clock edge where both read enables are high and empty is low. A read attempt with either enable low, or while empty, leaves the output word and the read pointer unchanged.
- R5: `rd_data` is registered and shows the word that was read starting one read-clock edge after the read. While `rd_oe` is low, the bus is high impedance.
- R6: With N the number of stored words, empty is high only when N = 0 and full is high only when N = 64, once the pointer crossing has settled.
- R7: Almost-empty is high when N <= AE, and almost-full is high when N >= 64 - AF, where AE and AF are the held offsets. Full implies almost-full, and empty implies almost-empty.
- R8: While `load_cfg` is high, each write-clock edge with both write enables high loads `wr_data[5:0]`. The first such edge loads AE, the second loads AF, and the third loads AE again, and so on. No data is stored. Dropping `load_cfg` restarts the sequence at AE.
- R9: A synchronous active-high `rst`, sampled by both clocks, clears both pointers. It sets empty and almost-empty, clears full and almost-full, sets AE = AF = 7, and zeroes the output word.
- R10: Correct order and flags hold both with one shared clock and with unrelated clocks. The pointers cross in Gray code, and each write-pointer change moves at most one Gray bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock, may be tied to wr_clk |
| rst | input | 1 | Synchronous active-high reset, seen by both clocks |
| wr_en_a | input | 1 | First write enable |
| wr_en_b | input | 1 | Second write enable |
| load_cfg | input | 1 | Routes qualified writes to the offset store |
| wr_data | input | 9 | Write word, or an offset in bits 5:0 |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| rd_oe | input | 1 | Output enable, low gives high impedance |
| rd_data | output | 9 | Registered read word |
| empty | output | 1 | Buffer empty (read domain) |
| almost_empty | output | 1 | Fill at or below AE (read domain) |
| full | output | 1 | Buffer full (write domain) |
| almost_full | output | 1 | Fill at or above 64 - AF (write domain) |

## Verification
The hardest state to reach from the ports is a write-pointer update that lands on a read-clock edge that has no fixed phase relation to the write clock. In that state the empty and almost-empty flags are held back by the synchroniser while words keep arriving. The stimulus first runs directed sequences on a shared clock. It then switches the read clock to an unrelated period and mixes random reads and writes around both boundaries. After each action it compares the output word with a queue model. At intervals it idles until the flags settle and compares them with thresholds computed from the model's offsets.

// File: rtl/dcfifo_pf_pkg.sv
`timescale 1ns/1ps
package dcfifo_pf_pkg;
  // Reset value of both watermark offsets
  localparam int unsigned DEF_OFS = 7;

  // Which offset the next load cycle writes
  typedef enum logic {SEL_AE = 1'b0, SEL_AF = 1'b1} ofs_sel_e;

  // Gray to binary over a wide vector; callers zero-extend and slice
  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dcfifo_pf_sync.sv
`timescale 1ns/1ps
module dcfifo_pf_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcfifo_pf_ram.sv
`timescale 1ns/1ps
module dcfifo_pf_ram #(
  parameter int W  = 9,
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcfifo_pf_wr.sv
`timescale 1ns/1ps
module dcfifo_pf_wr
  import dcfifo_pf_pkg::*;
#(
  parameter int W  = 9,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_a,
  input  logic          en_b,
  input  logic          load,
  input  logic [W-1:0]  din,
  input  logic [AW:0]   rgray_s,
  output logic          store,
  output logic [AW:0]   wbin,
  output logic [AW:0]   wgray,
  output logic          full,
  output logic          afull,
  output logic [AW-1:0] ae_ofs,
  output logic [AW-1:0] af_ofs
);
  localparam int CW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  ofs_sel_e       sel_q;
  logic           qual, cfg;
  logic [CW-1:0]  wbin_nx, rbin_s, cnt_nx;

  assign qual    = en_a & en_b;
  assign store   = qual & ~load & ~full;
  assign cfg     = qual & load;
  assign wbin_nx = wbin + CW'(store);
  assign rbin_s  = CW'(gray_to_bin(32'(rgray_s)));
  assign cnt_nx  = wbin_nx - rbin_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin   <= '0;
      wgray  <= '0;
      full   <= 1'b0;
      afull  <= 1'b0;
      sel_q  <= SEL_AE;
      ae_ofs <= AW'(DEF_OFS);
      af_ofs <= AW'(DEF_OFS);
    end else begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
      full  <= (cnt_nx == CW'(DEPTH));
      afull <= (cnt_nx >= (CW'(DEPTH) - CW'(af_ofs)));
      if (!load) begin
        sel_q <= SEL_AE;
      end else if (cfg) begin
        if (sel_q == SEL_AE) begin
          ae_ofs <= din[AW-1:0];
          sel_q  <= SEL_AF;
        end else begin
          af_ofs <= din[AW-1:0];
          sel_q  <= SEL_AE;
        end
      end
    end
  end
endmodule

// File: rtl/dcfifo_pf_rd.sv
`timescale 1ns/1ps
module dcfifo_pf_rd
  import dcfifo_pf_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_a,
  input  logic          en_b,
  input  logic [AW:0]   wgray_s,
  input  logic [AW-1:0] ae_ofs,
  output logic          fire,
  output logic [AW:0]   rbin,
  output logic [AW:0]   rgray,
  output logic          empty,
  output logic          aempty
);
  localparam int CW = AW + 1;

  logic [CW-1:0] rbin_nx, wbin_s, cnt_nx;

  assign fire    = en_a & en_b & ~empty;
  assign rbin_nx = rbin + CW'(fire);
  assign wbin_s  = CW'(gray_to_bin(32'(wgray_s)));
  assign cnt_nx  = wbin_s - rbin_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin   <= '0;
      rgray  <= '0;
      empty  <= 1'b1;
      aempty <= 1'b1;
    end else begin
      rbin   <= rbin_nx;
      rgray  <= rbin_nx ^ (rbin_nx >> 1);
      empty  <= (cnt_nx == '0);
      aempty <= (cnt_nx <= CW'(ae_ofs));
    end
  end
endmodule

// File: rtl/dcfifo_pf.sv
`timescale 1ns/1ps
module dcfifo_pf #(
  parameter int W  = 9,
  parameter int AW = 6
) (
  input  logic         wr_clk,
  input  logic         rd_clk,
  input  logic         rst,
  input  logic         wr_en_a,
  input  logic         wr_en_b,
  input  logic         load_cfg,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en_a,
  input  logic         rd_en_b,
  input  logic         rd_oe,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         almost_empty,
  output logic         full,
  output logic         almost_full
);
  localparam int CW = AW + 1;

  logic          w_store, r_fire;
  logic [CW-1:0] w_bin, w_gray, r_bin, r_gray, w_gray_s, r_gray_s;
  logic [AW-1:0] ae_ofs, af_ofs;
  logic [W-1:0]  dout;

  dcfifo_pf_wr #(.W(W), .AW(AW)) u_wr (
    .clk(wr_clk), .rst(rst), .en_a(wr_en_a), .en_b(wr_en_b), .load(load_cfg),
    .din(wr_data), .rgray_s(r_gray_s), .store(w_store), .wbin(w_bin),
    .wgray(w_gray), .full(full), .afull(almost_full),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  dcfifo_pf_rd #(.AW(AW)) u_rd (
    .clk(rd_clk), .rst(rst), .en_a(rd_en_a), .en_b(rd_en_b),
    .wgray_s(w_gray_s), .ae_ofs(ae_ofs), .fire(r_fire), .rbin(r_bin),
    .rgray(r_gray), .empty(empty), .aempty(almost_empty)
  );

  dcfifo_pf_sync #(.W(CW)) u_w2r (.clk(rd_clk), .rst(rst), .d(w_gray), .q(w_gray_s));
  dcfifo_pf_sync #(.W(CW)) u_r2w (.clk(wr_clk), .rst(rst), .d(r_gray), .q(r_gray_s));

  dcfifo_pf_ram #(.W(W), .AW(AW)) u_ram (
    .wclk(wr_clk), .we(w_store), .waddr(w_bin[AW-1:0]), .wdata(wr_data),
    .rclk(rd_clk), .rrst(rst), .re(r_fire), .raddr(r_bin[AW-1:0]), .rdata(dout)
  );

  assign rd_data = rd_oe ? dout : {W{1'bz}};
endmodule

// File: rtl/dcfifo_pf_chk.sv
`timescale 1ns/1ps
module dcfifo_pf_chk #(
  parameter int AW = 6
) (
  input logic        wr_clk,
  input logic        rd_clk,
  input logic        rst,
  input logic        wr_en_a,
  input logic        wr_en_b,
  input logic        load_cfg,
  input logic        rd_en_a,
  input logic        rd_en_b,
  input logic        empty,
  input logic        almost_empty,
  input logic        full,
  input logic        almost_full,
  input logic [AW:0] wbin,
  input logic [AW:0] wgray,
  input logic [AW:0] rbin
);
  // R2: a write with an enable low leaves the write pointer in place
  p_one_wr_enable_r2: assert property (@(posedge wr_clk) disable iff (rst)
    !(wr_en_a && wr_en_b) |=> $stable(wbin));
  // R3: write while full is dropped
  p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (rst)
    (full && wr_en_a && wr_en_b) |=> $stable(wbin));
  // R4: read while empty is dropped
  p_no_underflow_r4: assert property (@(posedge rd_clk) disable iff (rst)
    (empty && rd_en_a && rd_en_b) |=> $stable(rbin));
  // R4: a read with an enable low leaves the read pointer in place
  p_one_rd_enable_r4: assert property (@(posedge rd_clk) disable iff (rst)
    !(rd_en_a && rd_en_b) |=> $stable(rbin));
  // R7: flag nesting
  p_full_in_af_r7: assert property (@(posedge wr_clk) disable iff (rst)
    full |-> almost_full);
  p_empty_in_ae_r7: assert property (@(posedge rd_clk) disable iff (rst)
    empty |-> almost_empty);
  // R8: offset loading stores no data
  p_load_no_store_r8: assert property (@(posedge wr_clk) disable iff (rst)
    (load_cfg && wr_en_a && wr_en_b) |=> $stable(wbin));
  // R10: Gray pointer moves one bit at most
  p_gray_step_r10: assert property (@(posedge wr_clk) disable iff (rst)
    $onehot0(wgray ^ $past(wgray)));
endmodule

bind dcfifo_pf dcfifo_pf_chk #(.AW(AW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .wr_en_a(wr_en_a),
  .wr_en_b(wr_en_b), .load_cfg(load_cfg), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
  .empty(empty), .almost_empty(almost_empty), .full(full),
  .almost_full(almost_full), .wbin(w_bin), .wgray(w_gray), .rbin(r_bin)
);

// File: tb/dcfifo_pf_tb.sv
`timescale 1ns/1ps
module dcfifo_pf_tb;
  localparam int DEPTH = 64;

  logic       wclk = 1'b0, rclk_alt = 1'b0, same = 1'b1;
  logic       rst = 1'b1;
  logic       wr_en_a = 0, wr_en_b = 0, load_cfg = 0;
  logic [8:0] wr_data = '0;
  logic       rd_en_a = 0, rd_en_b = 0, rd_oe = 1;
  wire  [8:0] rd_data;
  wire        empty, almost_empty, full, almost_full;
  wire        rd_clk = same ? wclk : rclk_alt;

  always #2   wclk = ~wclk;
  always #3.5 rclk_alt = ~rclk_alt;

  dcfifo_pf u_dut (
    .wr_clk(wclk), .rd_clk(rd_clk), .rst(rst), .wr_en_a(wr_en_a),
    .wr_en_b(wr_en_b), .load_cfg(load_cfg), .wr_data(wr_data),
    .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .rd_oe(rd_oe), .rd_data(rd_data),
    .empty(empty), .almost_empty(almost_empty), .full(full),
    .almost_full(almost_full)
  );

  int         n_chk = 0, n_err = 0;
  logic [8:0] q[$];
  int         ae_m = 7, af_m = 7;
  bit         sel_m = 0;
  logic [8:0] last_out = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_ae(input int n); return n <= ae_m; endfunction
  function automatic bit exp_af(input int n); return n >= DEPTH - af_m; endfunction

  task automatic do_reset();
    @(negedge wclk); rst = 1;
    repeat (4) @(negedge wclk);
    repeat (4) @(negedge rd_clk);
    @(negedge wclk); rst = 0;
    q.delete(); ae_m = 7; af_m = 7; sel_m = 0; last_out = '0;
    repeat (2) @(negedge rd_clk);
  endtask

  task automatic wr(input logic [8:0] d, input bit ea, input bit eb);
    bit f;
    @(negedge wclk);
    wr_data = d; wr_en_a = ea; wr_en_b = eb; f = full;
    if (ea && eb) begin
      if (load_cfg) begin
        if (!sel_m) ae_m = int'(d[5:0]); else af_m = int'(d[5:0]);
        sel_m = ~sel_m;
      end else if (!f) q.push_back(d);
    end
    @(negedge wclk);
    wr_en_a = 0; wr_en_b = 0;
  endtask

  task automatic rd(input bit ea, input bit eb, input string req);
    bit e;
    logic [8:0] exp;
    @(negedge rd_clk);
    rd_en_a = ea; rd_en_b = eb; e = empty;
    exp = last_out;
    if (ea && eb && !e) exp = q.pop_front();
    @(negedge rd_clk);
    rd_en_a = 0; rd_en_b = 0;
    chk(rd_data === exp, req, int'(rd_data), int'(exp));
    last_out = exp;
  endtask

  task automatic set_load(input bit v);
    @(negedge wclk); load_cfg = v;
    if (!v) sel_m = 0;
  endtask

  task automatic settle_check(input string req);
    int n;
    repeat (10) @(negedge wclk);
    repeat (10) @(negedge rd_clk);
    n = q.size();
    chk(empty == (n == 0), {req, " empty"}, int'(empty), int'(n == 0));
    chk(almost_empty == exp_ae(n), {req, " almost_empty"}, int'(almost_empty), int'(exp_ae(n)));
    @(negedge wclk);
    chk(full == (n == DEPTH), {req, " full"}, int'(full), int'(n == DEPTH));
    chk(almost_full == exp_af(n), {req, " almost_full"}, int'(almost_full), int'(exp_af(n)));
  endtask

  task automatic fill_to(input int n);
    while (q.size() < n) wr(9'($urandom), 1, 1);
  endtask

  task automatic drain();
    while (q.size() > 0) rd(1, 1, "R1 drain order");
  endtask

  initial begin
    #600000;
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R9: reset state
    chk(empty == 1 && almost_empty == 1, "R9 reset empty flags", int'({empty, almost_empty}), 3);
    chk(full == 0 && almost_full == 0, "R9 reset full flags", int'({full, almost_full}), 0);
    chk(rd_data === 9'd0, "R9 reset output word", int'(rd_data), 0);

    // R1/R6/R7: small fill
    wr(9'h101, 1, 1); wr(9'h0a5, 1, 1); wr(9'h1ff, 1, 1);
    settle_check("R6 R7 three words");
    rd(1, 1, "R1 R5 first word"); rd(1, 1, "R1 second word"); rd(1, 1, "R1 third word");
    settle_check("R6 after drain");

    // R2: single write enable stores nothing
    wr(9'h055, 1, 0); wr(9'h0aa, 0, 1);
    settle_check("R2 one enable");
    // R4: read while empty keeps output
    rd(1, 1, "R4 read while empty");
    // R4: single read enable
    wr(9'h133, 1, 1);
    settle_check("R6 one word");
    rd(1, 0, "R4 one read enable"); rd(0, 1, "R4 other read enable");
    settle_check("R4 word still held");
    rd(1, 1, "R4 qualified read");

    // R3: fill to full and push extra
    fill_to(DEPTH);
    settle_check("R6 R7 full");
    wr(9'h1ee, 1, 1); wr(9'h1dd, 1, 1);
    settle_check("R3 writes while full");
    chk(q.size() == DEPTH, "R3 model depth", q.size(), DEPTH);
    drain();
    settle_check("R3 R6 empty after drain");

    // R8: offset load sequence
    set_load(1);
    wr(9'd3, 1, 1);    // AE=3
    wr(9'd10, 1, 1);   // AF=10
    wr(9'd5, 1, 0);    // not qualified
    wr(9'd5, 1, 1);    // wraps: AE=5
    set_load(0);
    set_load(1);
    wr(9'd2, 1, 1);    // restart: AE=2
    set_load(0);
    settle_check("R8 load stores nothing");
    fill_to(2);  settle_check("R8 AE=2 at two");
    fill_to(3);  settle_check("R8 AE=2 at three");
    fill_to(53); settle_check("R8 AF=10 at 53");
    fill_to(54); settle_check("R8 AF=10 at 54");

    // R5: high impedance
    drain();
    wr(9'h1a6, 1, 1);
    settle_check("R5 setup");
    rd(1, 1, "R5 registered word");
    @(negedge rd_clk); rd_oe = 0;
    #0.5;
    chk(rd_data === 9'bz || rd_data === 9'd0, "R5 output disabled", int'(rd_data), 0);
    @(negedge rd_clk); rd_oe = 1;
    #0.5;
    chk(rd_data === 9'h1a6, "R5 output re-enabled", int'(rd_data), 9'h1a6);

    // R9: reset with data inside restores default offsets
    fill_to(20);
    do_reset();
    settle_check("R9 reset with data");
    fill_to(7); settle_check("R9 default AE at seven");
    fill_to(8); settle_check("R9 default AE at eight");
    fill_to(56); settle_check("R9 default AF at 56");
    fill_to(57); settle_check("R9 default AF at 57");
    drain();

    // R10: unrelated clocks, random traffic
    for (int pass = 0; pass < 2; pass++) begin
      @(negedge wclk); rst = 1;
      same = (pass == 0);
      do_reset();
      for (int i = 0; i < 1500; i++) begin
        int r;
        r = int'($urandom % 16);
        if (r < 7 + pass * 2)      wr(9'($urandom), 1, 1);
        else if (r == 15)          wr(9'($urandom), 1, 0);
        else                       rd(1, 1, "R10 random order");
        if (i % 150 == 149) settle_check("R10 random flags");
      end
      fill_to(DEPTH);
      wr(9'h0f0, 1, 1);
      settle_check("R10 full boundary");
      drain();
      rd(1, 1, "R10 read past empty");
      settle_check("R10 empty boundary");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule